// File: doc/BRIEF.md
# Oversampling DPLL Bit Recovery

This block turns a demodulated one-bit receive line into data bits and 16-bit words. It samples the line at intervals counted in base units, where a base unit is one pulse of an external strobe. It takes either three or two samples per bit. Each sample records whether the line changed since the previous sample, and these flags fill a transition history that a carrier detector downstream can read.

One sample of each bit is the decision sample. There, the block looks at where the most recent transitions fell. It stretches or shortens the next interval by one base unit to pull its sampling phase onto the bit centre. It also decodes the bit as NRZI and packs the bit into a word.

Words are marked with a sentinel bit and leave the block with a one-cycle valid pulse. There is no backpressure. A signed counter of late minus early corrections shows how hard the loop is working.

Top module: `dpll_bit_recovery`

## Requirements
- R1: On every sample the history register shifts left by one. Its bit 0 takes 1 when the sampled line differs from the line at the previous sample, and 0 otherwise. The history and the previous-sample value reset to 0.
- R2: With `mode_2x` = 0, a phase counter steps 0,1,2,0... on each sample. Phase 0 is the decision sample. A sample at phase 1 or 2 schedules the next sample 4 base units later.
- R3: With `mode_2x` = 0, a decision sample takes the low three history bits, including the flag of the sample itself in bit 0. Pattern 3'b001 schedules the next sample 5 units later. Pattern 3'b100 schedules it 3 units later. Any other pattern schedules it 4 units later.
- R4: With `mode_2x` = 1, the phase alternates 0,1, and phase 0 is the decision sample. The nominal interval is 6 units. On a decision sample, low history bits 2'b01 give 7 units, 2'b10 give 5 units, and anything else gives 6 units.
- R5: On a decision sample the decoded bit is 1 when the line equals its value at the previous decision sample, and 0 otherwise. The stored decision value then takes the current line. Its reset value is 0.
- R6: A 17-bit word register resets to 0x10000. Each decoded bit shifts it right and enters at bit 16. When bit 0 becomes 1, bits 16:1 appear on `word_data` with `word_valid` high for exactly one cycle, and the register returns to 0x10000. The first bit received lands in `word_data[0]`.
- R7: `corr_count` is two's complement. It rises by 1 on each 5-unit (3x) or 7-unit (2x) choice, falls by 1 on each 3-unit (3x) or 5-unit (2x) choice, and wraps.
- R8: `rx_line` passes through two flops. A level driven before clock edge k is first seen by a sample taken at edge k+2.
- R9: The interval counts only cycles with `unit_stb` high. The first sample after reset comes on the first strobe. Each later sample comes on the strobe that completes the scheduled count.
- R10: During reset `sample_stb`, `word_valid`, `trans_hist` and `corr_count` are all 0. `sample_stb` pulses for one cycle after each sample, at the same edge the history updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_stb | input | 1 | One-cycle pulse marking one base unit of time |
| mode_2x | input | 1 | 0: three samples per bit, 1: two samples per bit |
| rx_line | input | 1 | Demodulated receive line, asynchronous |
| sample_stb | output | 1 | Pulse after each sample |
| trans_hist | output | HIST_W | Transition history, newest flag in bit 0 |
| word_valid | output | 1 | One-cycle pulse, word_data is valid |
| word_data | output | WORD_W | Assembled word, earliest bit in bit 0 |
| corr_count | output | CORR_W | Signed late-minus-early correction count |

## Verification
A wrong phase counter or a wrong interval choice moves the next sample, so `sample_stb` appears a unit early or late within a few dozen cycles. A wrong bit also shows up in `trans_hist` and `corr_count` at the following edge. A bad NRZI reference or word register stays hidden until the word completes, up to sixteen bit periods later, and then shows as a wrong value or a missing pulse on `word_valid`. The bench runs a cycle model next to the design and compares every sample pulse, the history and the counter at each sample, and every word. It uses steady, toggling and jittered line patterns in both modes and at two strobe rates.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_LATE  = 2'd1,
    ADJ_EARLY = 2'd2
  } adj_e;

  // Where the latest transitions sit decides whether the sample point drifts.
  function automatic adj_e classify_phase(input logic two_x, input logic [2:0] h);
    adj_e r;
    r = ADJ_NONE;
    if (two_x) begin
      if (h[1:0] == 2'b01)      r = ADJ_LATE;
      else if (h[1:0] == 2'b10) r = ADJ_EARLY;
    end else begin
      if (h == 3'b001)          r = ADJ_LATE;
      else if (h == 3'b100)     r = ADJ_EARLY;
    end
    return r;
  endfunction

  // NRZI: no change between decisions means a one.
  function automatic logic nrzi_decode(input logic now_lvl, input logic ref_lvl);
    return now_lvl == ref_lvl;
  endfunction

endpackage

// File: rtl/dpll_sync2.sv
module dpll_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      d_sync <= 1'b0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/dpll_unit_timer.sv
module dpll_unit_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_stb,
  input  logic [CNT_W-1:0] reload,
  output logic             fire
);
  logic [CNT_W-1:0] left_q;

  assign fire = unit_stb && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        left_q <= CNT_W'(1);
    else if (fire)     left_q <= reload;
    else if (unit_stb) left_q <= left_q - CNT_W'(1);
  end

  AST_TIMER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    left_q != '0);  // R9
  AST_RELOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> reload != '0);  // R9
endmodule

// File: rtl/dpll_word_pack.sv
module dpll_word_pack #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam int REG_W = WORD_W + 1;
  localparam logic [REG_W-1:0] MARKER = REG_W'(1) << WORD_W;

  logic [REG_W-1:0] acc_q;
  logic [REG_W-1:0] acc_shift;

  assign acc_shift = {bit_val, acc_q[REG_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= MARKER;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (bit_stb) begin
        if (acc_shift[0]) begin
          word_valid <= 1'b1;
          word_data  <= acc_shift[REG_W-1:1];
          acc_q      <= MARKER;
        end else begin
          acc_q <= acc_shift;
        end
      end
    end
  end

  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);  // R6
  AST_MARKER_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q != '0);  // R6
endmodule

// File: rtl/dpll_bit_recovery.sv
module dpll_bit_recovery
  import dpll_pkg::*;
#(
  parameter int HIST_W = 16,
  parameter int WORD_W = 16,
  parameter int CORR_W = 8,
  parameter int NOM_3X = 4,
  parameter int NOM_2X = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     unit_stb,
  input  logic                     mode_2x,
  input  logic                     rx_line,
  output logic                     sample_stb,
  output logic [HIST_W-1:0]        trans_hist,
  output logic                     word_valid,
  output logic [WORD_W-1:0]        word_data,
  output logic signed [CORR_W-1:0] corr_count
);
  localparam int MAX_IV = ((NOM_3X > NOM_2X) ? NOM_3X : NOM_2X) + 1;
  localparam int CNT_W  = $clog2(MAX_IV + 1);

  logic             line_s;
  logic             fire;
  logic             prev_samp_q;
  logic             last_dec_q;
  logic [1:0]       phase_q;
  logic             decision;
  logic             trans_now;
  logic [HIST_W-1:0] hist_next;
  adj_e             adj;
  logic [CNT_W-1:0] nominal;
  logic [CNT_W-1:0] reload;
  logic [1:0]       phase_last;
  logic             bit_stb;
  logic             bit_val;

  dpll_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_line),
    .d_sync  (line_s)
  );

  dpll_unit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_stb (unit_stb),
    .reload   (reload),
    .fire     (fire)
  );

  assign trans_now  = line_s ^ prev_samp_q;
  assign hist_next  = {trans_hist[HIST_W-2:0], trans_now};
  assign decision   = (phase_q == 2'd0);
  assign phase_last = mode_2x ? 2'd1 : 2'd2;
  assign adj        = decision ? classify_phase(mode_2x, hist_next[2:0]) : ADJ_NONE;
  assign nominal    = mode_2x ? CNT_W'(NOM_2X) : CNT_W'(NOM_3X);
  assign reload     = nominal + CNT_W'(adj == ADJ_LATE) - CNT_W'(adj == ADJ_EARLY);
  assign bit_stb    = fire && decision;
  assign bit_val    = nrzi_decode(line_s, last_dec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_samp_q <= 1'b0;
      last_dec_q  <= 1'b0;
      phase_q     <= 2'd0;
      trans_hist  <= '0;
      corr_count  <= '0;
      sample_stb  <= 1'b0;
    end else begin
      sample_stb <= fire;
      if (fire) begin
        prev_samp_q <= line_s;
        trans_hist  <= hist_next;
        phase_q     <= (phase_q >= phase_last) ? 2'd0 : phase_q + 2'd1;
        if (decision) last_dec_q <= line_s;
        if (adj == ADJ_LATE)       corr_count <= corr_count + CORR_W'(1);
        else if (adj == ADJ_EARLY) corr_count <= corr_count - CORR_W'(1);
      end
    end
  end

  dpll_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> trans_hist[HIST_W-1:1] == $past(trans_hist[HIST_W-2:0]));  // R1
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(trans_hist));  // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= phase_last);  // R2
  AST_INTERVAL_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (reload >= nominal - CNT_W'(1)) && (reload <= nominal + CNT_W'(1)));  // R3
  AST_QUIET_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !decision) |=> $stable(corr_count));  // R2
  AST_CORR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_count == $past(corr_count)) ||
    (corr_count == $past(corr_count) + CORR_W'(1)) ||
    (corr_count == $past(corr_count) - CORR_W'(1)));  // R7
  AST_WORD_ON_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> sample_stb);  // R6
endmodule

// File: tb/sim_dpll_bit_recovery.sv
module sim_dpll_bit_recovery;
  localparam int HW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ustb = 1'b0;
  logic mode2x = 1'b0;
  logic rx = 1'b0;
  logic        sample_stb;
  logic [HW-1:0] trans_hist;
  logic        word_valid;
  logic [15:0] word_data;
  logic signed [7:0] corr_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int udiv = 1;
  int ucnt = 0;
  logic [15:0] last_word = 16'h1234;
  int words_seen = 0;

  always #10 clk = ~clk;

  dpll_bit_recovery u0 (
    .clk(clk), .rst_n(rst_n), .unit_stb(ustb), .mode_2x(mode2x), .rx_line(rx),
    .sample_stb(sample_stb), .trans_hist(trans_hist), .word_valid(word_valid),
    .word_data(word_data), .corr_count(corr_count)
  );

  // unit strobe generator, driven away from the active edge
  always @(negedge clk) begin
    ustb <= (ucnt == 0);
    ucnt <= (ucnt + 1 >= udiv) ? 0 : ucnt + 1;
  end

  // reference model, restated from the requirements
  logic m_s1, m_s2, m_prev, m_dec, exp_samp;
  logic [HW-1:0] m_hist;
  logic [16:0] m_word;
  int m_cnt, m_ph, m_corr;
  logic [15:0] exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_dec = 0; exp_samp = 0;
      m_hist = '0; m_word = 17'h10000; m_cnt = 1; m_ph = 0; m_corr = 0;
      exp_q.delete();
    end else begin
      logic lv, tflag, b;
      int iv;
      exp_samp = 0;
      lv = m_s2;
      if (ustb) begin
        if (m_cnt == 1) begin
          exp_samp = 1;
          tflag = (lv != m_prev);
          m_prev = lv;
          m_hist = {m_hist[HW-2:0], tflag};
          iv = mode2x ? 6 : 4;
          if (m_ph == 0) begin
            if (mode2x) begin
              if (m_hist[1:0] == 2'b01) begin iv = 7; m_corr++; end
              else if (m_hist[1:0] == 2'b10) begin iv = 5; m_corr--; end
            end else begin
              if (m_hist[2:0] == 3'b001) begin iv = 5; m_corr++; end
              else if (m_hist[2:0] == 3'b100) begin iv = 3; m_corr--; end
            end
            b = (lv == m_dec);
            m_dec = lv;
            m_word = {b, m_word[16:1]};
            if (m_word[0]) begin
              exp_q.push_back(m_word[16:1]);
              m_word = 17'h10000;
            end
          end
          m_ph++;
          if (m_ph >= (mode2x ? 2 : 3)) m_ph = 0;
          m_cnt = iv;
        end else begin
          m_cnt--;
        end
      end
      m_s2 = m_s1;
      m_s1 = rx;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words and compares sample-time state
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_stb || exp_samp) begin
        check(sample_stb == exp_samp, mode2x ? "R4 sample time (R9)" : "R3 sample time (R9)",
              sample_stb, exp_samp);
        check(trans_hist == m_hist, "R1 history", trans_hist, m_hist);
        check(corr_count == 8'(m_corr), "R7 correction count", corr_count, 8'(m_corr));
      end
      if (word_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected word", word_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(word_data == e, "R6 word value (R5 R8)", word_data, e);
        end
        last_word <= word_data;
        words_seen <= words_seen + 1;
      end else if (exp_q.size() != 0) begin
        check(1'b0, "R6 missing word pulse", 0, exp_q[0]);
        exp_q.delete();
      end
    end
  end

  task automatic do_reset(input logic m, input int div);
    @(negedge clk);
    rst_n = 1'b0; mode2x = m; udiv = div; rx = 1'b0;
    repeat (3) @(negedge clk);
    check(sample_stb == 0 && word_valid == 0, "R10 reset outputs", {sample_stb, word_valid}, 0);
    check(trans_hist == 0 && corr_count == 0, "R10 reset state", {trans_hist, corr_count}, 0);
    rst_n = 1'b1;
  endtask

  task automatic hold(input logic lvl, input int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    // A: 3x, steady line -> all ones
    do_reset(1'b0, 1);
    hold(1'b0, 16 * 12 + 30);
    check(words_seen >= 1 && last_word == 16'hFFFF, "R5 steady line gives ones", last_word, 16'hFFFF);

    // B: 3x, one toggle per bit -> zeros once locked
    do_reset(1'b0, 1);
    for (int i = 0; i < 48; i++) hold(i[0], 12);
    check(last_word == 16'h0000, "R5 toggling line gives zeros", last_word, 0);

    // C: 3x, jittered data
    do_reset(1'b0, 1);
    for (int i = 0; i < 300; i++) hold(step_lfsr() ? ~rx : rx, (i % 2) ? 13 : 11);

    // D: 2x, strobe every other cycle, steady then jittered
    do_reset(1'b1, 2);
    hold(1'b0, 16 * 24 + 60);
    check(last_word == 16'hFFFF, "R4 2x steady line gives ones (R9)", last_word, 16'hFFFF);
    for (int i = 0; i < 200; i++) hold(step_lfsr() ? ~rx : rx, (i % 3 == 0) ? 25 : 23);

    // E: 2x at full strobe rate, jittered
    do_reset(1'b1, 1);
    for (int i = 0; i < 200; i++) hold(step_lfsr() ? ~rx : rx, (i % 2) ? 11 : 13);

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R6 words drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule